// File: doc/BRIEF.md
# Write-once RAM window relocation decoder

This block places a small on-chip RAM somewhere in a 16-bit CPU address space. It holds an 8-bit relocation register. The register's upper five bits give address bits 15:11 of a mapping window. The window's size is the RAM size rounded up to a power of two, and only the register bits above that size are used. For every CPU address the block reports whether the address falls on the RAM, through a combinational select. It also reports the byte offset inside the RAM.

The RAM size is a build parameter: 2, 4, 6, 8, 10, 12, 14 or 16 KiB. When the size is not a power of two, the RAM fills only part of its window. Register bit 0 then chooses the part: set places the RAM against the top of the window, clear places it at the bottom. For power-of-two sizes the RAM fills the whole window and bit 0 has no effect.

In normal operation the register takes only the first write after reset, so boot code can fix the map and later code cannot disturb it. A special-mode input lifts that restriction for test and debug.

Top module: `ramwin_top`

## Requirements
- R1: After reset, rd_data equals the RST_VAL parameter with bits 2:1 forced to zero, and the write lock is clear.
- R2: With special_mode low, the first write (wr_en high at a rising edge) after reset is stored. From the next cycle rd_data shows wr_data with bits 2:1 read as zero.
- R3: With special_mode low, every write after the first one is ignored and rd_data keeps its value.
- R4: While special_mode is high, every write is stored, whether or not the register was written before.
- R5: The window base is register bits 7:3 taken as address bits 15:11. Only the bits at or above the window size are compared: 15:11 for 2K, 15:12 for 4K, 15:13 for 6K and 8K, and 15:14 for 10K to 16K. The lower register bits have no effect on the decode.
- R6: sel is high exactly when the address lies in the occupied part of the window. For power-of-two sizes the whole window is occupied and bit 0 has no effect, so an 8K RAM with 0x38 or 0x39 decodes 0x2000 to 0x3FFF.
- R7: For 6K, 10K, 12K and 14K, bit 0 set puts the RAM against the top of the window. Bit 0 clear puts it at the bottom. For example, a 6K RAM with 0x09 decodes 0x0800 to 0x1FFF, and with 0x38 it decodes 0x2000 to 0x37FF.
- R8: When sel is high, offset equals the address minus the RAM's first address. When sel is low, offset is zero.
- R9: A stored write changes the decode from the cycle after the write edge. Before that edge, the old value still decides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | High: the register may be rewritten at will |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read-back, bits 2:1 read as zero |
| addr | input | 16 | CPU address |
| sel | output | 1 | RAM select, combinational |
| offset | output | 14 | Byte offset into the RAM, zero when not selected |

## Verification
The bench builds two copies of the block that share every input. One has a 6K RAM, so the top and bottom placement inside an 8K window can be checked at both of its edges. The other has an 8K RAM, to show that bit 0 is ignored when the RAM fills its window. The 6K copy is built with a reset value whose reserved bits are set, so the read-as-zero masking is visible straight after reset. Both copies share window bits 15:13, so the same register values also show that bits 12:11 do not matter.

// File: rtl/ramwin_pkg.sv
package ramwin_pkg;
  localparam int OFS_W = 14;
  localparam logic [7:0] CFG_KEEP = 8'hF9;

  function automatic int win_bits(input int kb);
    if (kb <= 2) return 11;
    else if (kb <= 4) return 12;
    else if (kb <= 8) return 13;
    else return 14;
  endfunction

  function automatic int ram_bytes(input int kb);
    return kb * 1024;
  endfunction

  function automatic bit size_is_pow2(input int kb);
    return ram_bytes(kb) == (1 << win_bits(kb));
  endfunction

  function automatic int top_gap(input int kb);
    return (1 << win_bits(kb)) - ram_bytes(kb);
  endfunction
endpackage

// File: rtl/ramwin_reg.sv
module ramwin_reg #(
  parameter logic [7:0] RST_VAL = 8'h09
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       special_mode,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] cfg_q,
  output logic       lock_q
);
  import ramwin_pkg::*;

  logic wr_take;
  assign wr_take = wr_en && (special_mode || !lock_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= RST_VAL & CFG_KEEP;
      lock_q <= 1'b0;
    end else if (wr_take) begin
      cfg_q  <= wr_data & CFG_KEEP;
      lock_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ramwin_decode.sv
module ramwin_decode #(
  parameter int RAM_KB = 6
) (
  input  logic [4:0]                  base_bits,
  input  logic                        align_top,
  input  logic [15:0]                 addr,
  output logic                        sel,
  output logic [ramwin_pkg::OFS_W-1:0] offset
);
  import ramwin_pkg::*;

  localparam int WB  = win_bits(RAM_KB);
  localparam int RB  = ram_bytes(RAM_KB);
  localparam logic [15:0] HI_MASK = 16'hFFFF << WB;
  localparam logic [OFS_W-1:0] GAP_T = OFS_W'(top_gap(RAM_KB));

  logic [15:0]      base16;
  logic             win_hit;
  logic [OFS_W-1:0] lo;
  logic [OFS_W-1:0] gap;
  logic             in_part;

  assign base16  = {base_bits, 11'b0};
  assign win_hit = ((addr ^ base16) & HI_MASK) == 16'h0;
  assign lo      = addr[OFS_W-1:0] & ~HI_MASK[OFS_W-1:0];

  generate
    if (size_is_pow2(RAM_KB)) begin : g_full
      logic unused_align;
      assign unused_align = align_top;
      assign gap = '0;
    end else begin : g_part
      assign gap = align_top ? GAP_T : '0;
    end
  endgenerate

  assign in_part = ({1'b0, lo} >= {1'b0, gap}) &&
                   ({1'b0, lo} <  ({1'b0, gap} + (OFS_W+1)'(RB)));
  assign sel     = win_hit && in_part;
  assign offset  = sel ? (lo - gap) : '0;
endmodule

// File: rtl/ramwin_top.sv
module ramwin_top #(
  parameter int         RAM_KB  = 6,
  parameter logic [7:0] RST_VAL = 8'h09
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         special_mode,
  input  logic                         wr_en,
  input  logic [7:0]                   wr_data,
  output logic [7:0]                   rd_data,
  input  logic [15:0]                  addr,
  output logic                         sel,
  output logic [ramwin_pkg::OFS_W-1:0] offset
);
  logic [7:0] cfg_q;
  logic       lock_q;
  logic       unused_rsvd;

  ramwin_reg #(.RST_VAL(RST_VAL)) reg_i (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
    .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg_q), .lock_q(lock_q)
  );

  ramwin_decode #(.RAM_KB(RAM_KB)) dec_i (
    .base_bits(cfg_q[7:3]), .align_top(cfg_q[0]), .addr(addr),
    .sel(sel), .offset(offset)
  );

  assign unused_rsvd = ^cfg_q[2:1];
  assign rd_data     = cfg_q;
endmodule

// File: rtl/ramwin_chk.sv
module ramwin_chk #(
  parameter int RAM_KB = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         special_mode,
  input logic                         wr_en,
  input logic [7:0]                   wr_data,
  input logic [7:0]                   rd_data,
  input logic [15:0]                  addr,
  input logic                         sel,
  input logic [ramwin_pkg::OFS_W-1:0] offset,
  input logic                         lock_q
);
  import ramwin_pkg::*;
  localparam int WB = win_bits(RAM_KB);
  localparam int RB = ram_bytes(RAM_KB);
  localparam int GP = top_gap(RAM_KB);
  localparam bit P2 = size_is_pow2(RAM_KB);

  AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock_q) |=> rd_data == ($past(wr_data) & 8'hF9)); // R2
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_q && !special_mode) |=> $stable(rd_data)); // R3
  AST_SPECIAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && special_mode) |=> rd_data == ($past(wr_data) & 8'hF9)); // R4
  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data)); // R3
  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> int'(offset) < RB); // R6
  AST_IDLE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> offset == '0); // R8
  AST_TOP_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd_data[0] && !P2) |-> (int'(addr) % (1 << WB)) >= GP); // R7
endmodule

bind ramwin_top ramwin_chk #(.RAM_KB(RAM_KB)) chk_i (
  .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .addr(addr), .sel(sel),
  .offset(offset), .lock_q(lock_q)
);

// File: tb/ramwin_top_tb_top.sv
module ramwin_top_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic special_mode = 0;
  logic wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [15:0] addr = 0;
  logic [7:0] rd6, rd8;
  logic sel6, sel8;
  logic [13:0] ofs6, ofs8;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ramwin_top #(.RAM_KB(6), .RST_VAL(8'h0F)) dut_i (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd6), .addr(addr), .sel(sel6), .offset(ofs6));
  ramwin_top #(.RAM_KB(8), .RST_VAL(8'h0F)) dut_p2_i (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd8), .addr(addr), .sel(sel8), .offset(ofs8));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent model: first RAM address for a given size and register value
  function automatic int ram_start(input int kb, input logic [7:0] cfg);
    int win, bytes, st;
    win = (kb <= 2) ? 2048 : (kb <= 4) ? 4096 : (kb <= 8) ? 8192 : 16384;
    bytes = kb * 1024;
    st = (int'(cfg) * 256) / win * win;
    if (cfg[0] && bytes != win) st = st + win - bytes;
    return st;
  endfunction

  task automatic probe(input string tag, input logic [7:0] cfg, input int a);
    int s6, s8;
    bit in6, in8;
    addr = a[15:0];
    #1;
    s6 = ram_start(6, cfg);
    s8 = ram_start(8, cfg);
    in6 = (a >= s6) && (a < s6 + 6144);
    in8 = (a >= s8) && (a < s8 + 8192);
    chk({tag, " sel6"}, int'(sel6), int'(in6));
    chk({tag, " ofs6 R8"}, int'(ofs6), in6 ? a - s6 : 0);
    chk({tag, " sel8"}, int'(sel8), int'(in8));
    chk({tag, " ofs8 R8"}, int'(ofs8), in8 ? a - s8 : 0);
  endtask

  task automatic sweep(input string tag, input logic [7:0] cfg);
    int s6;
    s6 = ram_start(6, cfg);
    probe(tag, cfg, s6 - 1);
    probe(tag, cfg, s6);
    probe(tag, cfg, s6 + 6143);
    probe(tag, cfg, s6 + 6144);
    probe(tag, cfg, ram_start(8, cfg) + 8191);
    probe(tag, cfg, (s6 + 8192) % 65536);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; special_mode = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd6", int'(rd6), 8'h09);
    chk("R1 rd8", int'(rd8), 8'h09);
    sweep("R7 reset top-align", 8'h09);
  endtask

  task automatic t_first_and_lock();
    do_reset();
    wr(8'h3E);
    chk("R2 first write", int'(rd6), 8'h38);
    sweep("R7 bottom-align 0x38", 8'h38);
    probe("R6 8K 0x38 top", 8'h38, 16'h3FFF);
    wr(8'h81);
    chk("R3 second write ignored", int'(rd6), 8'h38);
    chk("R3 second write ignored 8K", int'(rd8), 8'h38);
    sweep("R3 map unchanged", 8'h38);
  endtask

  task automatic t_special();
    do_reset();
    special_mode = 1;
    wr(8'h39);
    chk("R4 w1", int'(rd6), 8'h39);
    sweep("R6 8K ignores align", 8'h39);
    wr(8'h21);
    chk("R4 w2", int'(rd6), 8'h21);
    sweep("R5 low bits ignored", 8'h21);
    wr(8'h81);
    chk("R4 w3", int'(rd6), 8'h81);
    sweep("R7 high window", 8'h81);
    wr(8'hC0);
    chk("R4 w4", int'(rd6), 8'hC0);
    sweep("R5 top window", 8'hC0);
    special_mode = 0;
    wr(8'h09);
    chk("R3 locked after special", int'(rd6), 8'hC0);
  endtask

  task automatic t_timing();
    do_reset();
    @(negedge clk);
    wr_en = 1; wr_data = 8'h38; addr = 16'h2000;
    #1;
    chk("R9 old value before edge", int'(sel6), 0);
    @(negedge clk);
    wr_en = 0;
    #1;
    chk("R9 new value after edge", int'(sel6), 1);
    chk("R9 new offset", int'(ofs6), 0);
  endtask

  initial begin
    t_reset();
    t_first_and_lock();
    t_special();
    t_timing();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule